// File: doc/BRIEF.md
# Line Clamp and Blanking Pulse Generator

This block produces three per-line timing strobes for an image-sensor readout path: an active-low black-level clamp strobe, an active-low pre-blank strobe and an active-high horizontal blanking strobe. It also produces the four horizontal clock enables, which blanking can override. A 12-bit pixel counter sets the position within the line. The counter restarts a fixed number of clocks after the line sync falls. Each strobe changes level whenever the counter matches one of its programmed toggle positions.

Ten complete setting groups are present at the ports, one for each vertical sequence. The group in use, together with the odd/even line flag, is captured once per line, at the moment the counter restarts. A change to the sequence index therefore never alters a line that is already running. The blanking strobe has six toggle positions, so one line can hold more than one blanking window. A two-bit alternation code can split these toggles between odd and even lines. While blanking is active, the horizontal clock enables are driven to a per-group mask level.

Top module: `line_pulse_gen`

## Requirements
- R1: After reset, `clamp_n` and `preblank_n` are 1 and `hblank` is 0. Until the first line starts, `hclk_en` follows the unblanked pattern.
- R2: The pixel position reads 0 in the 17th clock after the first clock edge that samples `hd_n` low following a high. It then advances by one each clock. The level produced by the toggles at position p shows on the outputs one clock after position p.
- R3: At line start `clamp_n` takes that group's `clamp_pol` bit. It inverts at each of its two toggle positions. Toggle k of group s is `clamp_tog[(2*s+k)*12 +: 12]`.
- R4: `preblank_n` behaves as in R3 but independently, using `preblank_pol` and `preblank_tog` with the same layout.
- R5: `hblank` is 0 at every line start. It inverts at each enabled toggle position. Toggle j (0..5) of group s is `hb_tog[(6*s+j)*12 +: 12]`.
- R6: With `hb_alt[2*s +: 2]` = 0, all six blanking toggles are enabled on every line.
- R7: With alternation code 1, only toggles 0 and 1 are enabled on odd lines (`line_odd`=1), and only toggles 2 to 5 are enabled on even lines.
- R8: With alternation code 2 or 3, only toggles 0 and 1 are enabled on even lines, and only toggles 2 to 5 are enabled on odd lines.
- R9: Outside blanking, `hclk_en` = {~`hph_b`, `hph_b`, ~`hph_a`, `hph_a`}. Bit 0 is the first phase and bit 3 is the fourth.
- R10: During blanking, bits 0 and 2 of `hclk_en` equal the inverse of the group's `hb_mask` bit, and bits 1 and 3 equal the mask bit.
- R11: The group and the line parity are captured only at line start. Changing `seq_idx` during a line has no effect on that line. An index of 10 or more at line start keeps the previously captured group.
- R12: A toggle position that the counter does not reach before the next line start never takes effect, so the strobe holds its level until the line ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_n | input | 1 | Line sync, falling edge starts the restart delay |
| seq_idx | input | 4 | Vertical-sequence group to use for the next line |
| line_odd | input | 1 | 1 when the next line is odd |
| hph_a | input | 1 | Unblanked first/second phase source |
| hph_b | input | 1 | Unblanked third/fourth phase source |
| clamp_pol | input | 10 | Clamp strobe start level, one per group |
| clamp_tog | input | 240 | Clamp toggle positions, two per group |
| preblank_pol | input | 10 | Pre-blank start level, one per group |
| preblank_tog | input | 240 | Pre-blank toggle positions, two per group |
| hb_mask | input | 10 | Clock mask level during blanking, one per group |
| hb_alt | input | 20 | Odd/even alternation code, two bits per group |
| hb_tog | input | 720 | Blanking toggle positions, six per group |
| clamp_n | output | 1 | Clamp strobe, active low |
| preblank_n | output | 1 | Pre-blank strobe, active low |
| hblank | output | 1 | Horizontal blanking, active high |
| hclk_en | output | 4 | Horizontal clock enables, bit 0 = first phase |

## Verification
Position 0 of a line is due 18 bench cycles after the negative edge at which the bench pulls `hd_n` low. The level that results from the toggles at position p is due at bench cycle start+18+p+1. For each line, the driver computes the complete expected waveform from its own copy of the settings and queues one entry per cycle, each stamped with the bench cycle at which it is due. The monitor samples shortly after every falling clock edge and takes an entry off the queue only when its stamp equals the current cycle, so every comparison lands exactly on the cycle at which a result is due. The clock-phase inputs change on falling edges, and the monitor samples one time unit later, so the combinational `hclk_en` path is checked against the phase values already applied.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int LPG_PW     = 12;
  localparam int LPG_NSEQ   = 10;
  localparam int LPG_NHB    = 6;
  localparam int LPG_HD_DLY = 17;

  typedef enum logic [1:0] {
    ALT_NONE  = 2'd0,
    ALT_ODD   = 2'd1,
    ALT_EVEN  = 2'd2,
    ALT_EVEN2 = 2'd3
  } alt_e;

  // which blanking toggles take part on this line
  function automatic logic [LPG_NHB-1:0] hb_enables(input logic [1:0] mode, input logic odd);
    logic [LPG_NHB-1:0] pair;
    pair = '0;
    pair[1:0] = 2'b11;
    case (alt_e'(mode))
      ALT_NONE: return '1;
      ALT_ODD:  return odd ? pair : ~pair;
      default:  return odd ? ~pair : pair;
    endcase
  endfunction

  // {H4,H3,H2,H1}
  function automatic logic [3:0] h_levels(input logic blank, input logic mask,
                                          input logic pa, input logic pb);
    if (blank) return {mask, ~mask, mask, ~mask};
    return {~pb, pb, ~pa, pa};
  endfunction
endpackage

// File: rtl/lpg_pixcnt.sv
module lpg_pixcnt #(
  parameter int PW  = 12,
  parameter int DLY = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd_n,
  output logic [PW-1:0] pix,
  output logic          live,
  output logic          line_start
);
  localparam int            DW    = $clog2(DLY + 1);
  localparam logic [PW-1:0] PMAX  = '1;
  localparam logic [DW-1:0] DLOAD = DW'(DLY - 1);

  logic          hd_q;
  logic          armed;
  logic [DW-1:0] dly;
  logic          hd_fall;

  assign hd_fall    = hd_q & ~hd_n;
  assign line_start = armed && (dly == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= 1'b1;
      armed <= 1'b0;
      dly   <= '0;
      pix   <= '0;
      live  <= 1'b0;
    end else begin
      hd_q <= hd_n;
      if (hd_fall) begin
        armed <= 1'b1;
        dly   <= DLOAD;
      end else if (line_start) begin
        armed <= 1'b0;
      end else if (armed) begin
        dly <= dly - 1'b1;
      end
      if (line_start) begin
        pix  <= '0;
        live <= 1'b1;
      end else if (live) begin
        if (pix == PMAX) live <= 1'b0;
        else             pix  <= pix + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpg_bank.sv
module lpg_bank #(
  parameter int PW   = 12,
  parameter int NSEQ = 10,
  parameter int SW   = 4,
  parameter int NHB  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   odd_in,
  input  logic [SW-1:0]          seq_idx,
  input  logic [NSEQ-1:0]        clamp_pol,
  input  logic [NSEQ*2*PW-1:0]   clamp_tog,
  input  logic [NSEQ-1:0]        preblank_pol,
  input  logic [NSEQ*2*PW-1:0]   preblank_tog,
  input  logic [NSEQ-1:0]        hb_mask,
  input  logic [NSEQ*2-1:0]      hb_alt,
  input  logic [NSEQ*NHB*PW-1:0] hb_tog,
  output logic                   nxt_clamp_pol,
  output logic                   nxt_preblank_pol,
  output logic [SW-1:0]          act_idx,
  output logic                   act_odd,
  output logic                   act_mask,
  output logic [1:0]             act_alt,
  output logic [2*PW-1:0]        act_clamp_tog,
  output logic [2*PW-1:0]        act_preblank_tog,
  output logic [NHB*PW-1:0]      act_hb_tog
);
  logic [SW-1:0] sidx;
  int            base;

  assign sidx = (int'(seq_idx) < NSEQ) ? seq_idx : act_idx;

  always_comb begin
    base             = int'(sidx);
    nxt_clamp_pol    = clamp_pol[base];
    nxt_preblank_pol = preblank_pol[base];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_idx          <= '0;
      act_odd          <= 1'b0;
      act_mask         <= 1'b0;
      act_alt          <= '0;
      act_clamp_tog    <= '0;
      act_preblank_tog <= '0;
      act_hb_tog       <= '0;
    end else if (load) begin
      act_idx          <= sidx;
      act_odd          <= odd_in;
      act_mask         <= hb_mask[base];
      act_alt          <= hb_alt[base*2 +: 2];
      act_clamp_tog    <= clamp_tog[base*2*PW +: 2*PW];
      act_preblank_tog <= preblank_tog[base*2*PW +: 2*PW];
      act_hb_tog       <= hb_tog[base*NHB*PW +: NHB*PW];
    end
  end
endmodule

// File: rtl/lpg_toggle.sv
module lpg_toggle #(
  parameter int   PW  = 12,
  parameter int   NT  = 2,
  parameter logic RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             init_lvl,
  input  logic             live,
  input  logic [PW-1:0]    pix,
  input  logic [NT*PW-1:0] togs,
  input  logic [NT-1:0]    en,
  output logic             lvl,
  output logic             flip
);
  logic [NT-1:0] hit;

  for (genvar j = 0; j < NT; j++) begin : g_cmp
    assign hit[j] = en[j] && (togs[j*PW +: PW] == pix);
  end

  // coincident toggles cancel pairwise
  assign flip = live && (^hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lvl <= RST;
    else if (start) lvl <= init_lvl;
    else if (flip)  lvl <= ~lvl;
  end
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen import lpg_pkg::*; #(
  parameter int PW     = LPG_PW,
  parameter int NSEQ   = LPG_NSEQ,
  parameter int SW     = (NSEQ > 1) ? $clog2(NSEQ) : 1,
  parameter int HD_DLY = LPG_HD_DLY
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hd_n,
  input  logic [SW-1:0]              seq_idx,
  input  logic                       line_odd,
  input  logic                       hph_a,
  input  logic                       hph_b,
  input  logic [NSEQ-1:0]            clamp_pol,
  input  logic [NSEQ*2*PW-1:0]       clamp_tog,
  input  logic [NSEQ-1:0]            preblank_pol,
  input  logic [NSEQ*2*PW-1:0]       preblank_tog,
  input  logic [NSEQ-1:0]            hb_mask,
  input  logic [NSEQ*2-1:0]          hb_alt,
  input  logic [NSEQ*LPG_NHB*PW-1:0] hb_tog,
  output logic                       clamp_n,
  output logic                       preblank_n,
  output logic                       hblank,
  output logic [3:0]                 hclk_en
);
  localparam int NHB = LPG_NHB;

  logic [PW-1:0]     pix;
  logic              live;
  logic              line_start;
  logic              nxt_clamp_pol, nxt_preblank_pol;
  logic [SW-1:0]     act_idx;
  logic              act_odd, act_mask;
  logic [1:0]        act_alt;
  logic [2*PW-1:0]   act_clamp_tog, act_preblank_tog;
  logic [NHB*PW-1:0] act_hb_tog;
  logic [NHB-1:0]    hb_en;
  logic              clamp_flip, preblank_flip, hb_flip;

  lpg_pixcnt #(.PW(PW), .DLY(HD_DLY)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hd_n(hd_n),
    .pix(pix), .live(live), .line_start(line_start)
  );

  lpg_bank #(.PW(PW), .NSEQ(NSEQ), .SW(SW), .NHB(NHB)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(line_start), .odd_in(line_odd),
    .seq_idx(seq_idx),
    .clamp_pol(clamp_pol), .clamp_tog(clamp_tog),
    .preblank_pol(preblank_pol), .preblank_tog(preblank_tog),
    .hb_mask(hb_mask), .hb_alt(hb_alt), .hb_tog(hb_tog),
    .nxt_clamp_pol(nxt_clamp_pol), .nxt_preblank_pol(nxt_preblank_pol),
    .act_idx(act_idx), .act_odd(act_odd), .act_mask(act_mask), .act_alt(act_alt),
    .act_clamp_tog(act_clamp_tog), .act_preblank_tog(act_preblank_tog),
    .act_hb_tog(act_hb_tog)
  );

  assign hb_en = hb_enables(act_alt, act_odd);

  lpg_toggle #(.PW(PW), .NT(2), .RST(1'b1)) u_clamp (
    .clk(clk), .rst_n(rst_n), .start(line_start), .init_lvl(nxt_clamp_pol),
    .live(live), .pix(pix), .togs(act_clamp_tog), .en(2'b11),
    .lvl(clamp_n), .flip(clamp_flip)
  );

  lpg_toggle #(.PW(PW), .NT(2), .RST(1'b1)) u_preblank (
    .clk(clk), .rst_n(rst_n), .start(line_start), .init_lvl(nxt_preblank_pol),
    .live(live), .pix(pix), .togs(act_preblank_tog), .en(2'b11),
    .lvl(preblank_n), .flip(preblank_flip)
  );

  lpg_toggle #(.PW(PW), .NT(NHB), .RST(1'b0)) u_hblank (
    .clk(clk), .rst_n(rst_n), .start(line_start), .init_lvl(1'b0),
    .live(live), .pix(pix), .togs(act_hb_tog), .en(hb_en),
    .lvl(hblank), .flip(hb_flip)
  );

  assign hclk_en = h_levels(hblank, act_mask, hph_a, hph_b);
endmodule

// File: rtl/lpg_chk.sv
module lpg_chk #(
  parameter int PW  = 12,
  parameter int SW  = 4,
  parameter int NHB = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PW-1:0]  pix,
  input logic           live,
  input logic           line_start,
  input logic [SW-1:0]  act_idx,
  input logic           act_mask,
  input logic [NHB-1:0] hb_en,
  input logic           clamp_flip,
  input logic           preblank_flip,
  input logic           clamp_n,
  input logic           preblank_n,
  input logic           hblank,
  input logic [3:0]     hclk_en
);
  localparam logic [PW-1:0] PMAX = '1;

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (pix == '0) && live);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !line_start && pix != PMAX) |=> (pix == $past(pix) + 1'b1));

  p_clamp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !clamp_flip) |=> $stable(clamp_n));

  p_preblank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !preblank_flip) |=> $stable(preblank_n));

  p_hb_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !hblank);

  p_alt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (&hb_en) || ($countones(hb_en) == 2) || ($countones(hb_en) == 4));

  p_pairs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hclk_en[1] == ~hclk_en[0]) && (hclk_en[3] == ~hclk_en[2]));

  p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hblank |-> (hclk_en[0] == ~act_mask) && (hclk_en[2] == ~act_mask));

  p_sel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(act_idx));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && !line_start) |=> $stable(clamp_n) && $stable(preblank_n) && $stable(hblank));
endmodule

bind line_pulse_gen lpg_chk #(.PW(PW), .SW(SW), .NHB(lpg_pkg::LPG_NHB)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix(pix), .live(live), .line_start(line_start),
  .act_idx(act_idx), .act_mask(act_mask), .hb_en(hb_en),
  .clamp_flip(clamp_flip), .preblank_flip(preblank_flip),
  .clamp_n(clamp_n), .preblank_n(preblank_n), .hblank(hblank), .hclk_en(hclk_en)
);

// File: tb/sim_line_pulse_gen.sv
module sim_line_pulse_gen;
  localparam int CLK_P  = 10;
  localparam int PW     = 12;
  localparam int NSEQ   = 10;
  localparam int SW     = 4;
  localparam int NHB    = 6;
  localparam int PERIOD = 120;
  localparam int LIMIT  = 20000;

  logic clk = 1'b0;
  logic rst_n, hd_n, line_odd, hph_a, hph_b;
  logic [SW-1:0]          seq_idx;
  logic [NSEQ-1:0]        clamp_pol, preblank_pol, hb_mask;
  logic [NSEQ*2*PW-1:0]   clamp_tog, preblank_tog;
  logic [NSEQ*2-1:0]      hb_alt;
  logic [NSEQ*NHB*PW-1:0] hb_tog;
  logic clamp_n, preblank_n, hblank;
  logic [3:0] hclk_en;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cur_set = 0;

  // bench copy of the settings
  int m_cpol[NSEQ], m_ppol[NSEQ], m_mask[NSEQ], m_alt[NSEQ];
  int m_ct[NSEQ][2], m_pt[NSEQ][2], m_ht[NSEQ][NHB];

  typedef struct {
    int    cyc;
    logic  clp;
    logic  pbk;
    logic  hb;
    logic  mask;
    string tag;
  } exp_t;
  exp_t sbq[$];

  line_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .hd_n(hd_n), .seq_idx(seq_idx), .line_odd(line_odd),
    .hph_a(hph_a), .hph_b(hph_b),
    .clamp_pol(clamp_pol), .clamp_tog(clamp_tog),
    .preblank_pol(preblank_pol), .preblank_tog(preblank_tog),
    .hb_mask(hb_mask), .hb_alt(hb_alt), .hb_tog(hb_tog),
    .clamp_n(clamp_n), .preblank_n(preblank_n), .hblank(hblank), .hclk_en(hclk_en)
  );

  initial forever #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  function automatic logic [3:0] exp_h(input logic blank, input logic mask,
                                       input logic pa, input logic pb);
    logic [3:0] h;
    h[0] = blank ? !mask : pa;
    h[2] = blank ? !mask : pb;
    h[1] = !h[0];
    h[3] = !h[2];
    return h;
  endfunction

  task automatic init_cfg();
    for (int s = 0; s < NSEQ; s++) begin
      m_cpol[s] = s % 2;       m_ct[s][0] = 10 + s;  m_ct[s][1] = 40 + 2*s;
      m_ppol[s] = (s % 3 == 0); m_pt[s][0] = 5 + s;  m_pt[s][1] = 60 + s;
      m_mask[s] = (s / 2) % 2;  m_alt[s] = 0;
      m_ht[s][0] = 3 + s;  m_ht[s][1] = 20 + s; m_ht[s][2] = 50;
      m_ht[s][3] = 70;     m_ht[s][4] = 90 + s; m_ht[s][5] = 100 + s;
    end
    // set 1: code 1, preblank toggle at position 0, one unreachable blank toggle
    m_cpol[1] = 0; m_ct[1][0] = 25; m_ct[1][1] = 35;
    m_ppol[1] = 1; m_pt[1][0] = 0;  m_pt[1][1] = 80;
    m_mask[1] = 0; m_alt[1] = 1;
    m_ht[1][0] = 8; m_ht[1][1] = 15; m_ht[1][2] = 40; m_ht[1][3] = 55; m_ht[1][4] = 65; m_ht[1][5] = 3000;
    // set 2: code 2, clamp toggle never reached
    m_ct[2][0] = 3000; m_ct[2][1] = 50; m_mask[2] = 1; m_alt[2] = 2;
    m_ht[2][0] = 12; m_ht[2][1] = 30; m_ht[2][2] = 45; m_ht[2][3] = 60; m_ht[2][4] = 75; m_ht[2][5] = 95;
    // set 3: code 3
    m_mask[3] = 0; m_alt[3] = 3;
    m_ht[3][0] = 6; m_ht[3][1] = 18; m_ht[3][2] = 33; m_ht[3][3] = 44; m_ht[3][4] = 77; m_ht[3][5] = 88;
    for (int s = 0; s < NSEQ; s++) begin
      clamp_pol[s]    = m_cpol[s][0];
      preblank_pol[s] = m_ppol[s][0];
      hb_mask[s]      = m_mask[s][0];
      hb_alt[s*2 +: 2] = m_alt[s][1:0];
      for (int k = 0; k < 2; k++) begin
        clamp_tog[(2*s+k)*PW +: PW]    = m_ct[s][k][PW-1:0];
        preblank_tog[(2*s+k)*PW +: PW] = m_pt[s][k][PW-1:0];
      end
      for (int j = 0; j < NHB; j++) hb_tog[(NHB*s+j)*PW +: PW] = m_ht[s][j][PW-1:0];
    end
  endtask

  function automatic logic two_tog(input int init, input int t0, input int t1, input int q);
    int n;
    n = init + ((t0 < q) ? 1 : 0) + ((t1 < q) ? 1 : 0);
    return (n % 2) == 1;
  endfunction

  function automatic logic blank_lvl(input int s, input logic odd, input int q);
    bit first_ok, rest_ok;
    int n;
    if (m_alt[s] == 0)      begin first_ok = 1; rest_ok = 1; end
    else if (m_alt[s] == 1) begin first_ok = odd; rest_ok = !odd; end
    else                    begin first_ok = !odd; rest_ok = odd; end
    n = 0;
    for (int j = 0; j < NHB; j++)
      if (((j < 2) ? first_ok : rest_ok) && m_ht[s][j] < q) n++;
    return (n % 2) == 1;
  endfunction

  // driver: one line of PERIOD cycles; queues the expected waveform
  task automatic do_line(input int s_req, input logic odd, input string tag,
                         input int chg_at, input int chg_val);
    int c;
    exp_t e;
    @(negedge clk);
    hd_n = 1'b0;
    seq_idx = s_req[SW-1:0];
    line_odd = odd;
    if (s_req < NSEQ) cur_set = s_req;  // R11: out-of-range index keeps previous set
    c = cyc;
    for (int q = 0; q < PERIOD; q++) begin
      e.cyc  = c + 18 + q;              // R2: position 0 due 18 cycles after the drive
      e.clp  = two_tog(m_cpol[cur_set], m_ct[cur_set][0], m_ct[cur_set][1], q);
      e.pbk  = two_tog(m_ppol[cur_set], m_pt[cur_set][0], m_pt[cur_set][1], q);
      e.hb   = blank_lvl(cur_set, odd, q);
      e.mask = m_mask[cur_set][0];
      e.tag  = tag;
      sbq.push_back(e);
    end
    for (int n = 1; n < PERIOD; n++) begin
      @(negedge clk);
      hph_a = ~hph_a;
      if (!hph_a) hph_b = ~hph_b;
      if (n == 2) hd_n = 1'b1;
      if (n == chg_at) seq_idx = chg_val[SW-1:0];
    end
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0 && sbq[0].cyc == cyc) begin
        e = sbq.pop_front();
        check({e.tag, " R3 clamp"},    {3'b0, clamp_n},    {3'b0, e.clp});
        check({e.tag, " R4 preblank"}, {3'b0, preblank_n}, {3'b0, e.pbk});
        check({e.tag, " R5 hblank"},   {3'b0, hblank},     {3'b0, e.hb});
        check({e.tag, e.hb ? " R10 hclk" : " R9 hclk"}, hclk_en,
              exp_h(e.hb, e.mask, hph_a, hph_b));
      end
    end
  end

  initial begin
    rst_n = 1'b0; hd_n = 1'b1; seq_idx = '0; line_odd = 1'b0;
    hph_a = 1'b0; hph_b = 1'b1;
    init_cfg();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 clamp",    {3'b0, clamp_n},    4'b0001);
    check("R1 preblank", {3'b0, preblank_n}, 4'b0001);
    check("R1 hblank",   {3'b0, hblank},     4'b0000);
    check("R1 hclk",     hclk_en, exp_h(1'b0, 1'b0, hph_a, hph_b));

    do_line(0,  1'b1, "R6",      0, 0);  // all six toggles
    do_line(1,  1'b1, "R7 odd",  0, 0);  // first pair; preblank toggle at 0 (R2)
    do_line(1,  1'b0, "R7 R12",  0, 0);  // last four, one unreachable
    do_line(2,  1'b0, "R8 R12",  0, 0);  // code 2 even, clamp toggle unreachable
    do_line(2,  1'b1, "R8 odd",  0, 0);
    do_line(3,  1'b1, "R8 c3",   0, 0);  // code 3 behaves as 2
    do_line(12, 1'b0, "R11 oor", 0, 0);  // out of range keeps set 3
    do_line(5,  1'b1, "R11 mid", 30, 0); // change mid-line ignored
    do_line(9,  1'b0, "R2",      0, 0);
    wait (sbq.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done || cyc >= LIMIT);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got cycle %0d expected completion before %0d", cyc, LIMIT);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule